// File: doc/BRIEF.md
# Up/Down Timer with Toggle Output

This block is a 16-bit core counter paired with two 16-bit auxiliary counters. All three share one free-running clock divider. Each counter picks its own divide ratio of 2^n, with n from 3 to 10, and has its own run and direction controls. The core counter can also take its direction from an external pin. Each time the core counter wraps, in either direction, it inverts a toggle flip-flop that drives an output pin, and it raises an interrupt request.

Each auxiliary counter works in one of three modes:
- **Free counter:** it counts by itself.
- **Reload register:** on a core wrap, the core counter loads its value instead of wrapping.
- **Capture register:** it latches the core count when a selected edge appears on its own input pin.

A small word-wide register port gives access to all control fields, all counts and the sticky interrupt flags. Software clears the flags by writing ones.

Top module: `tmr_updown`

## Requirements
- R1: A free-running divider counter is cleared by reset and increments on every clock. A running timer with select field s (control bits [2:0]) takes one step on each clock edge where the low s+3 bits of that divider are all ones, which is once every 2^(s+3) clocks.
- R2: A timer whose run bit (control bit 3) is 0 holds its count.
- R3: Control bit 4 set to 1 makes a timer count down; 0 counts up. For the core timer, control bit 5 set to 1 hands the direction to `dirPin`, where a high level means down.
- R4: A core step up from 0xFFFF gives 0x0000, and a core step down from 0x0000 gives 0xFFFF. Each such wrap inverts `toggleOut` (0 after reset) and sets `irq[0]` on the same edge.
- R5: A register write of a count takes effect on the next clock edge. It overrides any step, reload or capture of that counter in that cycle, and it suppresses that counter's wrap event.
- R6: An auxiliary timer with mode field (control bits [6:5]) equal to 01 does not count. On a core wrap, the core loads the count of the lowest-numbered auxiliary timer in this mode instead of the wrap value, and that auxiliary timer's flag is set.
- R7: An auxiliary timer with mode 10 latches the core count as it stood before the edge. The trigger is an edge on its `auxIn` bit, chosen by control bits [8:7]: 00 none, 01 rising, 10 falling, 11 either. Edges are judged against the pin level at the previous clock edge, which is taken as 0 at reset. Each capture sets that timer's flag.
- R8: An auxiliary timer with mode 00 or 11 counts like the core, using its own select, run and direction bits. Its own wrap sets its flag and does not touch `toggleOut`.
- R9: `irq[k]` (k=0 core, 1 and 2 auxiliary) stays set until a write to address 6 with data bit k set. A set and a clear in the same cycle leave the flag set.
- R10: The register map is: address 2t holds the control register of timer t (t=0 core), address 2t+1 holds its count, address 6 holds the flags in bits [2:0], and address 7 reads 0. Unused bits read 0, and every register is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for `addr`, combinational |
| dirPin | input | 1 | External direction for the core timer, high = down |
| auxIn | input | 2 | Capture inputs, bit j for auxiliary timer j |
| toggleOut | output | 1 | Toggle flip-flop inverted on each core wrap |
| irq | output | 3 | Sticky interrupt flags: bit 0 core, bits 1 and 2 auxiliary |

## Verification
A divider phase or run-gating fault shows up in the count readback at the next expected step, at most 2^10 clocks later. A wrong direction appears after a single step. A corrupted wrap decision is visible on `toggleOut` and `irq[0]` on the same edge, and the toggle stays wrong from then on, so one miss is never hidden. A wrong reload source or capture edge leaves a wrong value in the core or auxiliary count that reads back on the next cycle and persists until it is overwritten.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NAUX   = 2;
  localparam int NTMR   = NAUX + 1;
  localparam int SEL_W  = 3;
  localparam int N_MIN  = 3;
  localparam int PSC_W  = N_MIN + (1 << SEL_W) - 1;
  localparam int CTL_W  = SEL_W + 6;
  localparam int ADDR_W = $clog2(2 * NTMR + 1);
  localparam logic [ADDR_W-1:0] ADDR_FLAGS = ADDR_W'(2 * NTMR);

  typedef enum logic [1:0] {
    MODE_FREE    = 2'd0,
    MODE_RELOAD  = 2'd1,
    MODE_CAPTURE = 2'd2,
    MODE_SPARE   = 2'd3
  } auxMode_e;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } capEdge_e;

  typedef struct packed {
    logic [NTMR-1:0] step;
    logic [NTMR-1:0] down;
    logic [NTMR-1:0] load;
    logic [NAUX-1:0] reloadEn;
    logic [NAUX-1:0] capture;
    logic [NTMR-1:0] flagClr;
  } strobe_t;

  function automatic logic [ADDR_W-1:0] ctlAddr(input int t);
    return ADDR_W'(2 * t);
  endfunction

  function automatic logic [ADDR_W-1:0] cntAddr(input int t);
    return ADDR_W'(2 * t + 1);
  endfunction
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [CTL_W-1:0]           ctlData,
  input  logic                       dirPin,
  input  logic [NAUX-1:0]            auxIn,
  input  logic [CNT_W-1:0]           coreCnt,
  input  logic [NAUX-1:0][CNT_W-1:0] auxCnt,
  input  logic [NTMR-1:0]            flags,
  output strobe_t                    strb,
  output logic [CNT_W-1:0]           rdData
);
  logic [PSC_W-1:0] psc;

  logic [SEL_W-1:0] coreSel;
  logic             coreRun;
  logic             coreDown;
  logic             coreExt;

  logic [SEL_W-1:0] auxSel  [NAUX];
  logic             auxRun  [NAUX];
  logic             auxDown [NAUX];
  logic [1:0]       auxMode [NAUX];
  logic [1:0]       auxEdge [NAUX];
  logic [NAUX-1:0]  auxPrev;

  function automatic logic tickAt(input logic [PSC_W-1:0] p, input logic [SEL_W-1:0] s);
    logic [PSC_W-1:0] mask;
    mask = PSC_W'((32'd1 << (32'(s) + N_MIN)) - 32'd1);
    return (p & mask) == mask;
  endfunction

  // divider, pin history and control registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psc      <= '0;
      auxPrev  <= '0;
      coreSel  <= '0;
      coreRun  <= 1'b0;
      coreDown <= 1'b0;
      coreExt  <= 1'b0;
      for (int j = 0; j < NAUX; j++) begin
        auxSel[j]  <= '0;
        auxRun[j]  <= 1'b0;
        auxDown[j] <= 1'b0;
        auxMode[j] <= MODE_FREE;
        auxEdge[j] <= EDGE_OFF;
      end
    end else begin
      psc     <= psc + PSC_W'(1);
      auxPrev <= auxIn;
      if (wrEn && addr == ctlAddr(0)) begin
        coreSel  <= ctlData[SEL_W-1:0];
        coreRun  <= ctlData[SEL_W];
        coreDown <= ctlData[SEL_W+1];
        coreExt  <= ctlData[SEL_W+2];
      end
      for (int j = 0; j < NAUX; j++) begin
        if (wrEn && addr == ctlAddr(j + 1)) begin
          auxSel[j]  <= ctlData[SEL_W-1:0];
          auxRun[j]  <= ctlData[SEL_W];
          auxDown[j] <= ctlData[SEL_W+1];
          auxMode[j] <= ctlData[SEL_W+3:SEL_W+2];
          auxEdge[j] <= ctlData[SEL_W+5:SEL_W+4];
        end
      end
    end
  end

  // strobes toward the datapath
  logic [NAUX-1:0] rise;
  logic [NAUX-1:0] fall;
  logic [NAUX-1:0] freeMode;

  always_comb begin
    strb         = '0;
    strb.step[0] = coreRun && tickAt(psc, coreSel);
    strb.down[0] = coreExt ? dirPin : coreDown;
    strb.load[0] = wrEn && addr == cntAddr(0);
    for (int j = 0; j < NAUX; j++) begin
      rise[j]     = auxIn[j] && !auxPrev[j];
      fall[j]     = !auxIn[j] && auxPrev[j];
      freeMode[j] = (auxMode[j] == MODE_FREE) || (auxMode[j] == MODE_SPARE);
      strb.step[j+1]   = auxRun[j] && freeMode[j] && tickAt(psc, auxSel[j]);
      strb.down[j+1]   = auxDown[j];
      strb.load[j+1]   = wrEn && addr == cntAddr(j + 1);
      strb.reloadEn[j] = auxMode[j] == MODE_RELOAD;
      strb.capture[j]  = (auxMode[j] == MODE_CAPTURE) &&
                         (((auxEdge[j] == EDGE_RISE) && rise[j]) ||
                          ((auxEdge[j] == EDGE_FALL) && fall[j]) ||
                          ((auxEdge[j] == EDGE_BOTH) && (rise[j] || fall[j])));
    end
    strb.flagClr = (wrEn && addr == ADDR_FLAGS) ? ctlData[NTMR-1:0] : '0;
  end

  // read mux
  always_comb begin
    rdData = '0;
    if (addr == ctlAddr(0)) begin
      rdData = CNT_W'({coreExt, coreDown, coreRun, coreSel});
    end else if (addr == cntAddr(0)) begin
      rdData = coreCnt;
    end else if (addr == ADDR_FLAGS) begin
      rdData = CNT_W'(flags);
    end
    for (int j = 0; j < NAUX; j++) begin
      if (addr == ctlAddr(j + 1)) begin
        rdData = CNT_W'({auxEdge[j], auxMode[j], auxDown[j], auxRun[j], auxSel[j]});
      end else if (addr == cntAddr(j + 1)) begin
        rdData = auxCnt[j];
      end
    end
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    strb,
  input  logic [CNT_W-1:0]           wrData,
  output logic [CNT_W-1:0]           coreCnt,
  output logic [NAUX-1:0][CNT_W-1:0] auxCnt,
  output logic [NTMR-1:0]            flags,
  output logic                       toggleOut
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic                       coreWrap;
  logic [CNT_W-1:0]           coreNext;
  logic [NAUX-1:0]            relPick;
  logic [CNT_W-1:0]           relVal;
  logic [NAUX-1:0]            auxWrap;
  logic [NAUX-1:0][CNT_W-1:0] auxNext;
  logic [NTMR-1:0]            flagSet;

  always_comb begin
    coreWrap = strb.step[0] && !strb.load[0] &&
               (strb.down[0] ? (coreCnt == '0) : (coreCnt == '1));
    relPick  = strb.reloadEn & (~strb.reloadEn + NAUX'(1));
    relVal   = '0;
    for (int j = 0; j < NAUX; j++) begin
      if (relPick[j]) relVal = relVal | auxCnt[j];
    end
    if (strb.load[0]) begin
      coreNext = wrData;
    end else if (coreWrap && (|strb.reloadEn)) begin
      coreNext = relVal;
    end else if (strb.step[0]) begin
      coreNext = strb.down[0] ? coreCnt - ONE : coreCnt + ONE;
    end else begin
      coreNext = coreCnt;
    end
    flagSet    = '0;
    flagSet[0] = coreWrap;
    for (int j = 0; j < NAUX; j++) begin
      auxWrap[j] = strb.step[j+1] && !strb.load[j+1] &&
                   (strb.down[j+1] ? (auxCnt[j] == '0) : (auxCnt[j] == '1));
      if (strb.load[j+1]) begin
        auxNext[j] = wrData;
      end else if (strb.capture[j]) begin
        auxNext[j] = coreCnt;
      end else if (strb.step[j+1]) begin
        auxNext[j] = strb.down[j+1] ? auxCnt[j] - ONE : auxCnt[j] + ONE;
      end else begin
        auxNext[j] = auxCnt[j];
      end
      flagSet[j+1] = auxWrap[j] || (strb.capture[j] && !strb.load[j+1]) ||
                     (coreWrap && relPick[j]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coreCnt   <= '0;
      auxCnt    <= '0;
      flags     <= '0;
      toggleOut <= 1'b0;
    end else begin
      coreCnt   <= coreNext;
      for (int j = 0; j < NAUX; j++) auxCnt[j] <= auxNext[j];
      flags     <= (flags & ~strb.flagClr) | flagSet;
      toggleOut <= toggleOut ^ coreWrap;
    end
  end
endmodule

// File: rtl/tmr_updown.sv
module tmr_updown
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  input  logic              dirPin,
  input  logic [1:0]        auxIn,
  output logic              toggleOut,
  output logic [2:0]        irq
);
  strobe_t                    strb;
  logic [CNT_W-1:0]           coreCnt;
  logic [NAUX-1:0][CNT_W-1:0] auxCnt;
  logic [NTMR-1:0]            flags;

  tmr_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .addr    (addr),
    .ctlData (wrData[CTL_W-1:0]),
    .dirPin  (dirPin),
    .auxIn   (auxIn),
    .coreCnt (coreCnt),
    .auxCnt  (auxCnt),
    .flags   (flags),
    .strb    (strb),
    .rdData  (rdData)
  );

  tmr_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (wrData),
    .coreCnt   (coreCnt),
    .auxCnt    (auxCnt),
    .flags     (flags),
    .toggleOut (toggleOut)
  );

  assign irq = flags;
endmodule

// File: rtl/tmr_updown_chk.sv
module tmr_updown_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       wrEn,
  input logic [ADDR_W-1:0]          addr,
  input logic [CNT_W-1:0]           wrData,
  input logic                       toggleOut,
  input logic [NTMR-1:0]            irq,
  input logic [CNT_W-1:0]           coreCnt,
  input logic [NAUX-1:0][CNT_W-1:0] auxCnt,
  input strobe_t                    strb
);
  // R4
  toggle_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(toggleOut) |-> irq[0]);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.step[0] && !strb.load[0]) |=> $stable(coreCnt));

  // R3
  core_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step[0] && !strb.load[0] && coreCnt != '0 && coreCnt != '1) |=>
      (coreCnt == ($past(strb.down[0]) ? CNT_W'($past(coreCnt) - CNT_W'(1))
                                       : CNT_W'($past(coreCnt) + CNT_W'(1)))));

  // R5
  load_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load[0] |=> (coreCnt == $past(wrData)));

  // R7
  capture_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture[0] && !strb.load[1]) |=> (auxCnt[0] == $past(coreCnt)));

  // R9
  for (genvar k = 0; k < NTMR; k++) begin : g_sticky
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(irq[k]) |-> $past(wrEn && addr == ADDR_FLAGS && wrData[k]));
  end
endmodule

bind tmr_updown tmr_updown_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .addr      (addr),
  .wrData    (wrData),
  .toggleOut (toggleOut),
  .irq       (irq),
  .coreCnt   (coreCnt),
  .auxCnt    (auxCnt),
  .strb      (strb)
);

// File: tb/test_tmr_updown.sv
`timescale 1ns/1ps
module test_tmr_updown;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        dirPin = 1'b0;
  logic [1:0]  auxIn = '0;
  logic        toggleOut;
  logic [2:0]  irq;

  int    nChecks = 0;
  int    nErrors = 0;
  bit    checking = 1'b0;
  string phaseTag = "R10";
  logic [2:0] watch = 3'd1;

  // reference state
  int mPsc;
  int mCtl [3];
  int mCnt [3];
  int mFlags;
  int mTog;
  int mPrev [2];

  always #2.5 clk = ~clk;

  tmr_updown i_tmr_updown (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .dirPin(dirPin), .auxIn(auxIn),
    .toggleOut(toggleOut), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit tickM(input int sel);
    int period;
    period = 1 << (sel + 3);
    return (mPsc % period) == (period - 1);
  endfunction

  function automatic int mRead(input int a);
    if (a < 6) return (a % 2 == 1) ? mCnt[a/2] : mCtl[a/2];
    if (a == 6) return mFlags;
    return 0;
  endfunction

  // cycle model built from the requirements
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPsc = 0; mFlags = 0; mTog = 0;
      for (int t = 0; t < 3; t++) begin mCtl[t] = 0; mCnt[t] = 0; end
      for (int j = 0; j < 2; j++) mPrev[j] = 0;
    end else begin
      int  nCnt [3];
      bit  stp [3];
      bit  dn [3];
      bit  wr [3];
      int  mode [3];
      int  relSrc;
      int  setF;
      int  clr;
      bit  wrap0;
      for (int t = 0; t < 3; t++) begin
        mode[t] = (t == 0) ? 0 : ((mCtl[t] >> 5) & 3);
        stp[t]  = ((mCtl[t] >> 3) & 1) == 1 && (mode[t] == 0 || mode[t] == 3) &&
                  tickM(mCtl[t] & 7);
        dn[t]   = (t == 0 && ((mCtl[0] >> 5) & 1) == 1) ? dirPin : (((mCtl[t] >> 4) & 1) == 1);
        wr[t]   = wrEn && int'(addr) == 2 * t + 1;
      end
      wrap0 = stp[0] && !wr[0] && (dn[0] ? mCnt[0] == 0 : mCnt[0] == 65535);
      relSrc = 0;
      for (int t = 2; t >= 1; t--) if (mode[t] == 1) relSrc = t;
      setF = 0;
      if (wrap0) setF = setF | 1;
      if (wrap0 && relSrc != 0) setF = setF | (1 << relSrc);
      if (wr[0]) nCnt[0] = int'(wrData);
      else if (wrap0 && relSrc != 0) nCnt[0] = mCnt[relSrc];
      else if (stp[0]) nCnt[0] = (mCnt[0] + (dn[0] ? -1 : 1)) & 16'hFFFF;
      else nCnt[0] = mCnt[0];
      for (int t = 1; t < 3; t++) begin
        int  e;
        bit  r, f, cap;
        e   = (mCtl[t] >> 7) & 3;
        r   = auxIn[t-1] == 1'b1 && mPrev[t-1] == 0;
        f   = auxIn[t-1] == 1'b0 && mPrev[t-1] == 1;
        cap = mode[t] == 2 && ((e == 1 && r) || (e == 2 && f) || (e == 3 && (r || f)));
        if (wr[t]) nCnt[t] = int'(wrData);
        else if (cap) nCnt[t] = mCnt[0];
        else if (stp[t]) nCnt[t] = (mCnt[t] + (dn[t] ? -1 : 1)) & 16'hFFFF;
        else nCnt[t] = mCnt[t];
        if (cap && !wr[t]) setF = setF | (1 << t);
        if (stp[t] && !wr[t] && (dn[t] ? mCnt[t] == 0 : mCnt[t] == 65535)) setF = setF | (1 << t);
      end
      clr = (wrEn && addr == 3'd6) ? (int'(wrData) & 7) : 0;
      mFlags = (mFlags & ~clr) | setF;
      if (wrap0) mTog = 1 - mTog;
      if (wrEn && addr == 3'd0) mCtl[0] = int'(wrData) & 16'h3F;
      if (wrEn && addr == 3'd2) mCtl[1] = int'(wrData) & 16'h1FF;
      if (wrEn && addr == 3'd4) mCtl[2] = int'(wrData) & 16'h1FF;
      for (int t = 0; t < 3; t++) mCnt[t] = nCnt[t];
      mPsc = (mPsc + 1) % 1024;
      for (int j = 0; j < 2; j++) mPrev[j] = int'(auxIn[j]);
    end
  end

  // monitor, away from the active edge
  always begin
    @(posedge clk);
    #1;
    if (checking) begin
      chk("R4", int'(toggleOut), mTog);
      chk("R9", int'(irq), mFlags);
      chk(phaseTag, int'(rdData), mRead(int'(addr)));
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wrEn = 1'b0;
      addr = watch;
    end
  endtask

  task automatic wrReg(input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; addr = 3'(a); wrData = 16'(d);
    @(negedge clk);
    wrEn = 1'b0; addr = watch;
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog expired at %0t", $time);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R10: reset state at the ports
    chk("R10", int'(toggleOut), 0);
    chk("R10", int'(irq), 0);
    chk("R10", int'(rdData), 0);
    rstN = 1'b1;
    checking = 1'b1;
    phaseTag = "R10";
    for (int a = 0; a < 8; a++) begin @(negedge clk); addr = 3'(a); end

    phaseTag = "R1"; watch = 3'd1;
    wrReg(0, 16'h0008); idle(80);
    wrReg(0, 16'h000F); idle(2200);

    phaseTag = "R2";
    wrReg(0, 16'h0000); idle(40);
    wrReg(0, 16'h0009); idle(40);

    phaseTag = "R3";
    wrReg(0, 16'h0018); idle(40);
    wrReg(0, 16'h0028);
    for (int i = 0; i < 6; i++) begin dirPin = ~dirPin; idle(20); end

    phaseTag = "R4";
    wrReg(0, 16'h0008); wrReg(1, 16'hFFFD); idle(40);
    wrReg(0, 16'h0018); wrReg(1, 16'h0002); idle(40);
    wrReg(6, 7);

    phaseTag = "R5";
    wrReg(0, 16'h0008);
    for (int i = 0; i < 20; i++) wrReg(1, 16'hFFFF);
    wrReg(1, 16'h1000); idle(12);

    phaseTag = "R6";
    wrReg(2, 16'h0020); wrReg(3, 16'h1234);
    wrReg(4, 16'h0020); wrReg(5, 16'h5555);
    wrReg(1, 16'hFFFE); idle(30);
    watch = 3'd6; idle(3); watch = 3'd1;
    wrReg(2, 16'h0000); wrReg(1, 16'hFFFE); idle(30);
    watch = 3'd6; idle(3);
    wrReg(6, 7);

    phaseTag = "R7"; watch = 3'd3;
    wrReg(2, 16'h00C0); wrReg(4, 16'h0140);
    for (int i = 0; i < 12; i++) begin auxIn = 2'(i); idle(7); watch = (i % 2 == 0) ? 3'd5 : 3'd3; end
    wrReg(2, 16'h01C0);
    for (int i = 0; i < 8; i++) begin auxIn[0] = ~auxIn[0]; idle(5); end
    wrReg(6, 7);

    phaseTag = "R8"; watch = 3'd3;
    wrReg(2, 16'h0008); wrReg(3, 16'hFFFE); idle(30);
    watch = 3'd5;
    wrReg(4, 16'h0018); wrReg(5, 16'h0001); idle(30);
    watch = 3'd6; idle(3);

    phaseTag = "R9";
    wrReg(1, 16'hFFFF); wrReg(3, 16'hFFFF);
    for (int i = 0; i < 20; i++) wrReg(6, 7);
    idle(20);

    phaseTag = "R10";
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      addr = 3'($urandom % 8);
      wrEn = ($urandom % 8) == 0;
      case ($urandom % 4)
        0: wrData = 16'($urandom);
        1: wrData = 16'hFFF0 | 16'($urandom % 16);
        2: wrData = 16'($urandom % 16);
        default: wrData = 16'($urandom % 512);
      endcase
      if (wrEn && addr[0] == 1'b0 && addr != 3'd6) wrData[2:0] = 3'($urandom % 2);
      if (($urandom % 16) == 0) dirPin = ~dirPin;
      if (($urandom % 4) == 0) auxIn = 2'($urandom);
    end
    @(negedge clk); wrEn = 1'b0;
    idle(4);
    summary();
    $finish;
  end
endmodule